// File: doc/BRIEF.md
# Card Interface Power-State Controller

This block holds the power state of an SD/MMC host interface and decides how the card-side pins are driven in each state. A single-cycle write port loads a 2-bit power field and a direction-polarity option. The block turns the stored state into per-line pad controls for the card clock, the command line and the data lines. Each line has an output enable and an output value. Each command and data line also has a direction signal for an external level-shifting transceiver.

The block has four states. Straight out of reset every pad is released (high impedance). In the power-cycle state all lines are pulled low, so the card cannot be powered through its signal pins. In the power-off state the lines are held high and the card clock does not toggle. In the power-on state the card clock runs through to its pad. The interface-enable flag stays low until a fixed number of card-clock rising edges has been seen in power-on. Only after that do the command and data pads follow the protocol engines. Before that, those pads idle high.

The card clock arrives as a level signal, `card_ck_in`, produced by a divider in the same clock domain. Its rising edges are counted on `clk`.

Top module: `card_pwr_ctrl`

## Requirements
- R1: One cycle after a synchronous reset, the power field reads 00 and the direction-polarity bit reads 0. Every pad output enable is 0 and every pad value is 0. `iface_en` is 0.
- R2: After a write of field 10 (power-cycle), the clock, command and all data pads have output enable 1 and value 0.
- R3: After a write of field 00 (power-off) or 01 (reserved, treated as power-off), all pads have output enable 1 and value 1, so the clock is static high. `iface_en` is 0 and the field reads back exactly as written.
- R4: After a write of field 11 (power-on), the clock pad is enabled and copies `card_ck_in`. The command and data pads are driven high. `iface_en` stays 0 until INIT_CLKS (default 74) rising edges of `card_ck_in` have been sampled in power-on. It reads 1 from the cycle after the clock edge that samples the last of them.
- R5: While `iface_en` is 1, each command and data pad's enable and value copy the engine inputs of that line.
- R6: Leaving power-on clears the edge count, so a later return to power-on needs the full INIT_CLKS edges again. A write of 11 while already in power-on does not restart the count.
- R7: Each command and data direction output equals that pad's output enable XOR the stored direction-polarity bit. The polarity bit is loaded with every accepted write.
- R8: Rising edges of `card_ck_in` outside power-on are not counted.
- R9: When `wr_en` is 0, the write inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the power field and polarity |
| wr_pwr | input | 2 | Power field to write (00 off, 01 reserved, 10 cycle, 11 on) |
| wr_dirpol | input | 1 | Direction polarity to write |
| card_ck_in | input | 1 | Divided card clock level |
| eng_cmd_oe | input | 1 | Command-line enable from the protocol engine |
| eng_cmd_o | input | 1 | Command-line value from the protocol engine |
| eng_dat_oe | input | DW | Data-line enables from the protocol engine |
| eng_dat_o | input | DW | Data-line values from the protocol engine |
| pwr_field | output | 2 | Stored power field |
| dirpol | output | 1 | Stored direction polarity |
| iface_en | output | 1 | Interface enable |
| ck_oe | output | 1 | Clock pad output enable |
| ck_o | output | 1 | Clock pad value |
| cmd_oe | output | 1 | Command pad output enable |
| cmd_o | output | 1 | Command pad value |
| cmd_dir | output | 1 | Command transceiver direction |
| dat_oe | output | DW | Data pad output enables |
| dat_o | output | DW | Data pad values |
| dat_dir | output | DW | Data transceiver directions |

## Verification
The bench first goes after the difference between the reset state and power-off. Both read field 00, so a design that merged them would drive the pads high straight out of reset instead of releasing them. It also checks the enable boundary by counting edges one short of and exactly at INIT_CLKS. An off-by-one counter shows up as the flag rising a pulse early or late. Clock edges are applied while in power-off and around leave-and-return sequences: a design that counted stray edges or kept a stale count would enable early. A rewrite of power-on while already enabled is also tried, since a design that restarted on it would drop the flag.

// File: rtl/card_pwr_pkg.sv
// Package: shared encodings for the card interface power-state controller.
// Assumes: the power field codes are fixed by the register layout.
package card_pwr_pkg;

    localparam logic [1:0] PWR_OFF   = 2'b00;
    localparam logic [1:0] PWR_RSVD  = 2'b01;
    localparam logic [1:0] PWR_CYCLE = 2'b10;
    localparam logic [1:0] PWR_ON    = 2'b11;

    // How a single pad is driven.
    typedef enum logic [1:0] {
        PAD_HIZ  = 2'd0,
        PAD_LOW  = 2'd1,
        PAD_HIGH = 2'd2,
        PAD_FUNC = 2'd3
    } pad_mode_e;

endpackage

// File: rtl/pwr_field_reg.sv
// Module: pwr_field_reg
// Holds the power field and the direction polarity. It also tracks whether
// any write has happened since reset, which separates the released reset
// state from power-off (both read 00).
// Assumes: wr_en is a single-cycle strobe in the clk domain.
module pwr_field_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_pwr,
    input  logic       wr_dirpol,
    output logic [1:0] field_q,
    output logic       dirpol_q,
    output logic       released_q,
    output logic       on_q
);
    import card_pwr_pkg::*;

    // Load the field and polarity on a write; the first write ends the released state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q    <= PWR_OFF;
            dirpol_q   <= 1'b0;
            released_q <= 1'b1;
        end else if (wr_en) begin
            field_q    <= wr_pwr;
            dirpol_q   <= wr_dirpol;
            released_q <= 1'b0;
        end
    end

    // Decode power-on from the stored state.
    always_comb begin
        on_q = !released_q && (field_q == PWR_ON);
    end

endmodule

// File: rtl/init_clk_gate.sv
// Module: init_clk_gate
// Counts rising edges of the card clock while in power-on and raises
// enable once INIT_CLKS edges have been seen. The count clears in every
// cycle spent outside power-on.
// Assumes: card_ck is a level synchronous to clk, slower than clk/2.
module init_clk_gate #(
    parameter int INIT_CLKS = 74
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on,
    input  logic card_ck,
    output logic enable
);
    localparam int CW = $clog2(INIT_CLKS + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(INIT_CLKS);

    logic          ck_prev;
    logic [CW-1:0] cnt;
    logic          rise;

    // Remember the previous card clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ck_prev <= 1'b0;
        else        ck_prev <= card_ck;
    end

    // Rising edge of the card clock.
    always_comb begin
        rise = card_ck && !ck_prev;
    end

    // Count edges in power-on, saturating at INIT_CLKS; clear elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (!on)                     cnt <= '0;
        else if (rise && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end

    // Enable once the full run of edges is in.
    always_comb begin
        enable = on && (cnt == CNT_MAX);
    end

endmodule

// File: rtl/pad_mux.sv
// Module: pad_mux
// Turns a pad mode into an output enable and a value for one line.
// Assumes: the engine inputs matter only in PAD_FUNC.
module pad_mux (
    input  card_pwr_pkg::pad_mode_e mode,
    input  logic                    eng_oe,
    input  logic                    eng_o,
    output logic                    pad_oe,
    output logic                    pad_o
);
    import card_pwr_pkg::*;

    // Select the drive for this pad.
    always_comb begin
        unique case (mode)
            PAD_HIZ:  begin pad_oe = 1'b0;   pad_o = 1'b0;  end
            PAD_LOW:  begin pad_oe = 1'b1;   pad_o = 1'b0;  end
            PAD_HIGH: begin pad_oe = 1'b1;   pad_o = 1'b1;  end
            default:  begin pad_oe = eng_oe; pad_o = eng_o; end
        endcase
    end

endmodule

// File: rtl/card_pwr_ctrl.sv
// Module: card_pwr_ctrl (top)
// Card interface power-state controller. It stores the power field, gates
// the interface enable behind an initial run of card clocks, and drives the
// clock, command and data pads plus the transceiver directions.
// Assumes: synchronous active-low reset; all inputs are in the clk domain.
module card_pwr_ctrl #(
    parameter int DW        = 8,
    parameter int INIT_CLKS = 74
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_pwr,
    input  logic          wr_dirpol,
    input  logic          card_ck_in,
    input  logic          eng_cmd_oe,
    input  logic          eng_cmd_o,
    input  logic [DW-1:0] eng_dat_oe,
    input  logic [DW-1:0] eng_dat_o,
    output logic [1:0]    pwr_field,
    output logic          dirpol,
    output logic          iface_en,
    output logic          ck_oe,
    output logic          ck_o,
    output logic          cmd_oe,
    output logic          cmd_o,
    output logic          cmd_dir,
    output logic [DW-1:0] dat_oe,
    output logic [DW-1:0] dat_o,
    output logic [DW-1:0] dat_dir
);
    import card_pwr_pkg::*;

    logic      released;
    logic      on;
    logic      en;
    pad_mode_e ck_mode;
    pad_mode_e io_mode;

    pwr_field_reg u_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_pwr     (wr_pwr),
        .wr_dirpol  (wr_dirpol),
        .field_q    (pwr_field),
        .dirpol_q   (dirpol),
        .released_q (released),
        .on_q       (on)
    );

    init_clk_gate #(.INIT_CLKS(INIT_CLKS)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .on      (on),
        .card_ck (card_ck_in),
        .enable  (en)
    );

    // Pick pad modes for the clock line and the command/data lines.
    always_comb begin
        if (released) begin
            ck_mode = PAD_HIZ;
            io_mode = PAD_HIZ;
        end else if (pwr_field == PWR_CYCLE) begin
            ck_mode = PAD_LOW;
            io_mode = PAD_LOW;
        end else if (on) begin
            ck_mode = PAD_FUNC;
            io_mode = en ? PAD_FUNC : PAD_HIGH;
        end else begin
            ck_mode = PAD_HIGH;
            io_mode = PAD_HIGH;
        end
    end

    pad_mux u_ck_pad (
        .mode   (ck_mode),
        .eng_oe (1'b1),
        .eng_o  (card_ck_in),
        .pad_oe (ck_oe),
        .pad_o  (ck_o)
    );

    pad_mux u_cmd_pad (
        .mode   (io_mode),
        .eng_oe (eng_cmd_oe),
        .eng_o  (eng_cmd_o),
        .pad_oe (cmd_oe),
        .pad_o  (cmd_o)
    );

    for (genvar i = 0; i < DW; i++) begin : g_dat
        pad_mux u_dat_pad (
            .mode   (io_mode),
            .eng_oe (eng_dat_oe[i]),
            .eng_o  (eng_dat_o[i]),
            .pad_oe (dat_oe[i]),
            .pad_o  (dat_o[i])
        );
    end

    // Transceiver directions follow the enables with the selected polarity.
    always_comb begin
        cmd_dir = cmd_oe ^ dirpol;
        dat_dir = dat_oe ^ {DW{dirpol}};
    end

    // Interface enable output.
    always_comb begin
        iface_en = en;
    end

endmodule

// File: rtl/card_pwr_ctrl_chk.sv
// Module: card_pwr_ctrl_chk
// Assertion checker bound to card_pwr_ctrl.
module card_pwr_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_pwr,
    input logic          card_ck_in,
    input logic [1:0]    pwr_field,
    input logic          iface_en,
    input logic          ck_oe,
    input logic          ck_o,
    input logic          cmd_oe,
    input logic          cmd_o,
    input logic [DW-1:0] dat_oe,
    input logic [DW-1:0] dat_o
);

    assert_hiz_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pwr_field == 2'b00 && !ck_oe && !cmd_oe && dat_oe == '0 && !iface_en));

    assert_cycle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_field == 2'b10) |-> (ck_oe && !ck_o && cmd_oe && !cmd_o && &dat_oe && dat_o == '0));

    assert_off_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_field[1] == 1'b0 && ck_oe) |-> (ck_o && cmd_o && &dat_o && !iface_en));

    assert_en_only_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iface_en |-> (pwr_field == 2'b11));

    assert_en_after_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iface_en) |-> $past(card_ck_in));

    assert_en_drop_on_leave_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iface_en && wr_en && wr_pwr != 2'b11) |=> !iface_en);

endmodule

bind card_pwr_ctrl card_pwr_ctrl_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_pwr     (wr_pwr),
    .card_ck_in (card_ck_in),
    .pwr_field  (pwr_field),
    .iface_en   (iface_en),
    .ck_oe      (ck_oe),
    .ck_o       (ck_o),
    .cmd_oe     (cmd_oe),
    .cmd_o      (cmd_o),
    .dat_oe     (dat_oe),
    .dat_o      (dat_o)
);

// File: tb/tb_card_pwr_ctrl.sv
module tb_card_pwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int NCLK       = 74;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_pwr = 2'b00;
    logic          wr_dirpol = 1'b0;
    logic          card_ck_in = 1'b0;
    logic          eng_cmd_oe = 1'b0;
    logic          eng_cmd_o = 1'b0;
    logic [DW-1:0] eng_dat_oe = '0;
    logic [DW-1:0] eng_dat_o = '0;
    logic [1:0]    pwr_field;
    logic          dirpol, iface_en, ck_oe, ck_o, cmd_oe, cmd_o, cmd_dir;
    logic [DW-1:0] dat_oe, dat_o, dat_dir;

    card_pwr_ctrl #(.DW(DW), .INIT_CLKS(NCLK)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pwr(wr_pwr),
        .wr_dirpol(wr_dirpol), .card_ck_in(card_ck_in),
        .eng_cmd_oe(eng_cmd_oe), .eng_cmd_o(eng_cmd_o),
        .eng_dat_oe(eng_dat_oe), .eng_dat_o(eng_dat_o),
        .pwr_field(pwr_field), .dirpol(dirpol), .iface_en(iface_en),
        .ck_oe(ck_oe), .ck_o(ck_o), .cmd_oe(cmd_oe), .cmd_o(cmd_o),
        .cmd_dir(cmd_dir), .dat_oe(dat_oe), .dat_o(dat_o), .dat_dir(dat_dir)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit started = 0;

    // Behavioural reference state
    bit       m_rel = 1, m_pol = 0, m_prev = 0;
    bit [1:0] m_field = 0;
    int       m_cnt = 0;

    always @(posedge clk) begin
        bit cur_on;
        if (!rst_n) begin
            m_rel = 1; m_pol = 0; m_prev = 0; m_field = 0; m_cnt = 0;
        end else begin
            cur_on = !m_rel && m_field == 2'b11;
            if (!cur_on) m_cnt = 0;
            else if (card_ck_in && !m_prev && m_cnt < NCLK) m_cnt++;
            m_prev = card_ck_in;
            if (wr_en) begin
                m_field = wr_pwr; m_pol = wr_dirpol; m_rel = 0;
            end
        end
        started = 1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the reference on each falling edge.
    always @(negedge clk) begin
        bit on, en, ck_oe_e, ck_o_e, io_oe_c, io_o_c;
        logic [DW-1:0] doe, dout;
        logic [32:0] exp_v, act_v;
        string tag;
        if (started && !done) begin
            on = !m_rel && m_field == 2'b11;
            en = on && m_cnt == NCLK;
            if (m_rel) begin
                ck_oe_e = 0; ck_o_e = 0; io_oe_c = 0; io_o_c = 0; doe = '0; dout = '0; tag = "R1";
            end else if (m_field == 2'b10) begin
                ck_oe_e = 1; ck_o_e = 0; io_oe_c = 1; io_o_c = 0; doe = '1; dout = '0; tag = "R2";
            end else if (on && en) begin
                ck_oe_e = 1; ck_o_e = card_ck_in; io_oe_c = eng_cmd_oe; io_o_c = eng_cmd_o;
                doe = eng_dat_oe; dout = eng_dat_o; tag = "R5";
            end else if (on) begin
                ck_oe_e = 1; ck_o_e = card_ck_in; io_oe_c = 1; io_o_c = 1; doe = '1; dout = '1; tag = "R4";
            end else begin
                ck_oe_e = 1; ck_o_e = 1; io_oe_c = 1; io_o_c = 1; doe = '1; dout = '1; tag = "R3";
            end
            exp_v = {ck_oe_e, ck_o_e, io_oe_c, io_o_c, io_oe_c ^ m_pol, doe, dout,
                     doe ^ {DW{m_pol}}, en, m_field, m_pol};
            act_v = {ck_oe, ck_o, cmd_oe, cmd_o, cmd_dir, dat_oe, dat_o, dat_dir,
                     iface_en, pwr_field, dirpol};
            check({tag, " R7 model"}, 64'(act_v), 64'(exp_v));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_pwr(input logic [1:0] f, input logic pol);
        wr_en = 1; wr_pwr = f; wr_dirpol = pol;
        tick();
        wr_en = 0;
    endtask

    task automatic pulse_ck(input int n);
        for (int i = 0; i < n; i++) begin
            card_ck_in = 1; tick();
            card_ck_in = 0; tick();
        end
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1: released state after reset
        check("R1", {ck_oe, cmd_oe, dat_oe, iface_en, pwr_field, dirpol}, '0);

        // R2: power-cycle drives low
        write_pwr(2'b10, 0);
        check("R2", {ck_oe, ck_o, cmd_oe, cmd_o, dat_oe, dat_o}, {4'b1010, 8'hFF, 8'h00});

        // R3: reserved code behaves as power-off, reads back as written
        write_pwr(2'b01, 0);
        check("R3", {ck_oe, ck_o, cmd_o, dat_o, pwr_field}, {3'b111, 8'hFF, 2'b01});

        // R8: clock edges while off are not counted
        pulse_ck(20);
        check("R8", iface_en, 0);

        // R4: enable after exactly NCLK edges; R7 with polarity 1
        write_pwr(2'b11, 1);
        check("R4", {ck_oe, cmd_o, dat_o}, {2'b11, 8'hFF});
        check("R7", {cmd_dir, dat_dir}, {1'b0, 8'h00});
        pulse_ck(NCLK - 1);
        check("R4", iface_en, 0);
        check("R8", iface_en, 0);
        pulse_ck(1);
        check("R4", iface_en, 1);

        // R5: engine patterns reach the pads
        eng_cmd_oe = 1; eng_cmd_o = 0; eng_dat_oe = 8'hA5; eng_dat_o = 8'h3C;
        tick();
        check("R5", {cmd_oe, cmd_o, dat_oe, dat_o}, {2'b10, 8'hA5, 8'h3C});
        check("R7", {cmd_dir, dat_dir}, {1'b0, 8'h5A});
        eng_cmd_oe = 0; eng_cmd_o = 1; eng_dat_oe = 8'h0F; eng_dat_o = 8'hF0;
        card_ck_in = 1;
        tick();
        check("R5", {ck_o, cmd_oe, cmd_o, dat_oe, dat_o}, {3'b101, 8'h0F, 8'hF0});
        card_ck_in = 0;

        // R6: rewriting power-on keeps enable; polarity reloads
        write_pwr(2'b11, 0);
        check("R6", iface_en, 1);
        check("R7", {cmd_dir, dat_dir}, {1'b0, 8'h0F});

        // R9: writes without strobe ignored
        wr_pwr = 2'b10; wr_dirpol = 1;
        repeat (3) tick();
        check("R9", {pwr_field, dirpol, iface_en}, {2'b11, 1'b0, 1'b1});

        // R6: leave and return restarts the count
        write_pwr(2'b00, 0);
        check("R6", iface_en, 0);
        write_pwr(2'b11, 0);
        pulse_ck(NCLK - 1);
        check("R6", iface_en, 0);
        pulse_ck(1);
        check("R6", iface_en, 1);

        // R3: explicit power-off
        write_pwr(2'b00, 0);
        check("R3", {ck_o, cmd_o, dat_o, iface_en}, {2'b11, 8'hFF, 1'b0});

        // R1: reset from a driven state
        rst_n = 0; tick(); rst_n = 1; tick();
        check("R1", {ck_oe, cmd_oe, dat_oe, pwr_field}, '0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule